// File: doc/BRIEF.md
# Split-word read sequencer for a shared address/data bus

This block runs asynchronous single reads against an external 16-bit device whose address and data travel on one set of wires. The host issues a 32-bit word read. The block carries it out as two 16-bit device accesses in a row, the low half first. It then joins the two halves into one 32-bit result, which it returns with a one-cycle completion pulse.

Every edge of every strobe inside an access comes from one tick counter, which restarts at zero for each access. Chip-select, address-valid and output-enable each have a programmable start tick and a programmable stop tick. A separate tick sets when the bus data is captured, and another sets where the access ends. An optional idle gap of programmable length can be placed between the two halves. During the gap every strobe is released, so the device sees output-enable deassert and then assert again. All timing fields and the address are taken at the moment a request is accepted.

The controller has four states. `ST_IDLE` waits for a request. `ST_ACCESS` runs one 16-bit access. `ST_GAP` idles between the halves. `ST_DONE` presents the result for one cycle. The transitions are:
- accept: `ST_IDLE` to `ST_ACCESS`, taken when `req_valid` is high.
- split: `ST_ACCESS` to `ST_ACCESS` with the high half selected, taken at the end of the low half when no gap applies.
- rest: `ST_ACCESS` to `ST_GAP`.
- resume: `ST_GAP` to `ST_ACCESS`, high half.
- finish: `ST_ACCESS` to `ST_DONE`, at the end of the high half.
- retire: `ST_DONE` to `ST_IDLE`.

Top module: `amux_rd_seq`

## Requirements
- R1: `req_ready` is high only in the idle state. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. The first access begins in the next cycle at tick 0, and `req_ready` stays low until the transaction retires.
- R2: Let k be the tick within an access. `cs_n` is low exactly when cs_on <= k < cs_off and is high otherwise. `adv_n` is low exactly when adv_on <= k < adv_off and is high otherwise. Both strobes are high outside accesses.
- R3: `oe_n` is low exactly when oe_on <= k < oe_off. `dir_in` (1 = bus input) is high from tick oe_on to the end of the access, and low outside accesses.
- R4: An access lasts cyc_time ticks (k = 0 to cyc_time-1). `ad_in` is captured during tick acc_time. Valid settings are cyc_time from 1 to 31, acc_time < cyc_time, and every off tick <= cyc_time.
- R5: For the 32-bit word index W, `addr_hi` shows W[25:15] throughout both accesses. `ad_oe` is high exactly while k < adv_off. While `ad_oe` is high, `ad_out` is {W[14:0], h}, where h is 0 for the low-half access and 1 for the high-half access. Otherwise `ad_out` is 0.
- R6: The low-half access fills `rd_data[15:0]` and the high-half access fills `rd_data[31:16]`. `done` is high for one cycle, the cycle right after the last tick of the high half, and `rd_data` holds the joined word in that cycle. `req_ready` rises in the next cycle.
- R7: When gap_en is 1 and gap_len > 0, exactly gap_len idle cycles separate the two accesses. In those cycles all strobes are high, `ad_oe` is 0 and `dir_in` is 0. Otherwise the high-half access starts in the cycle right after the low half ends.
- R8: The timing fields and `req_word` are sampled at acceptance, and later changes have no effect on the transaction in flight. `req_valid` is ignored while the block is busy.
- R9: After reset the block is idle: `req_ready` is 1, all strobes are high, `done`, `ad_oe` and `dir_in` are 0, and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock; one tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host read request |
| req_ready | output | 1 | High when a request can be accepted |
| req_word | input | 26 | 32-bit word index to read |
| cs_on | input | 4 | Chip-select assertion tick |
| cs_off | input | 5 | Chip-select release tick |
| adv_on | input | 4 | Address-valid assertion tick |
| adv_off | input | 5 | Address-valid release tick; also ends the address drive |
| oe_on | input | 4 | Output-enable assertion tick; bus turns to input |
| oe_off | input | 5 | Output-enable release tick |
| acc_time | input | 5 | Tick at which bus data is captured |
| cyc_time | input | 5 | Access length in ticks |
| gap_en | input | 1 | Enables the idle gap between the halves |
| gap_len | input | 4 | Idle gap length in cycles |
| done | output | 1 | One-cycle pulse: result valid |
| rd_data | output | 32 | Joined 32-bit read result |
| cs_n | output | 1 | Chip-select, active low |
| adv_n | output | 1 | Address-valid, active low |
| oe_n | output | 1 | Output-enable, active low |
| dir_in | output | 1 | Bus direction, 1 = device drives |
| ad_oe | output | 1 | Drive enable for the shared bus (0 = high impedance) |
| ad_out | output | 16 | Address driven onto the shared bus |
| ad_in | input | 16 | Data read from the shared bus |
| addr_hi | output | 11 | Upper address bits on dedicated pins |

## Verification
The bench sweeps cycle lengths from 4 to 8 ticks. For each length it tries every capture tick, and it shifts the on and off ticks of the strobes from run to run. The bus input follows a pattern that depends on both the half and the tick, so capturing one tick early or late, or swapping the halves, produces a wrong word. Each setting runs three times: with the gap disabled but a nonzero length programmed, with the gap enabled at length zero, and with a real gap. This separates a correct gap from one that leaks through when it should be inert. Some runs hold `req_valid` high during the whole transaction. In every run the timing inputs and address are scrambled just after acceptance, so any path that uses live inputs instead of the sampled values shows up. Extreme runs at the one-tick and 31-tick cycle lengths, including a 15-cycle gap, cover the edges of the counter range.

// File: rtl/amux_rd_pkg.sv
package amux_rd_pkg;

    localparam int ON_W   = 4;
    localparam int TICK_W = 5;
    localparam int GAP_W  = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACCESS,
        ST_GAP,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic [ON_W-1:0]   cs_on;
        logic [TICK_W-1:0] cs_off;
        logic [ON_W-1:0]   adv_on;
        logic [TICK_W-1:0] adv_off;
        logic [ON_W-1:0]   oe_on;
        logic [TICK_W-1:0] oe_off;
        logic [TICK_W-1:0] acc_time;
        logic [TICK_W-1:0] cyc_time;
        logic              gap_en;
        logic [GAP_W-1:0]  gap_len;
    } rd_timing_t;

endpackage

// File: rtl/amux_rd_tick_cnt.sv
module amux_rd_tick_cnt #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] tick
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick <= '0;
        end else if (clr) begin
            tick <= '0;
        end else if (inc) begin
            tick <= tick + W'(1);
        end
    end

endmodule

// File: rtl/amux_rd_window.sv
module amux_rd_window #(
    parameter int ON_W   = 4,
    parameter int TICK_W = 5
) (
    input  logic              active,
    input  logic [TICK_W-1:0] tick,
    input  logic [ON_W-1:0]   t_on,
    input  logic [TICK_W-1:0] t_off,
    output logic              hit
);

    localparam int PAD_W = TICK_W - ON_W;

    logic [TICK_W-1:0] on_ext;

    // Widen the start tick to the counter width before comparing.
    assign on_ext = {{PAD_W{1'b0}}, t_on};
    assign hit    = active && (tick >= on_ext) && (tick < t_off);

endmodule

// File: rtl/amux_rd_assemble.sv
module amux_rd_assemble #(
    parameter int HALF_W = 16,
    parameter int PARTS  = 2,
    localparam int SEL_W = (PARTS > 1) ? $clog2(PARTS) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cap,
    input  logic [SEL_W-1:0]          sel,
    input  logic [HALF_W-1:0]         din,
    output logic [PARTS*HALF_W-1:0]   word
);

    // One holding register per slice of the result; only the selected slice loads.
    for (genvar p = 0; p < PARTS; p++) begin : g_part
        logic [HALF_W-1:0] part_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                part_q <= '0;
            end else if (cap && (sel == SEL_W'(p))) begin
                part_q <= din;
            end
        end

        assign word[p*HALF_W +: HALF_W] = part_q;
    end

endmodule

// File: rtl/amux_rd_seq.sv
module amux_rd_seq
    import amux_rd_pkg::*;
#(
    parameter int ADDR_W = 28,
    parameter int MUX_W  = 16,
    localparam int WORD_IDX_W = ADDR_W - 2,
    localparam int HI_W       = ADDR_W - 1 - MUX_W,
    localparam int RES_W      = 2 * MUX_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [WORD_IDX_W-1:0] req_word,
    input  logic [ON_W-1:0]       cs_on,
    input  logic [TICK_W-1:0]     cs_off,
    input  logic [ON_W-1:0]       adv_on,
    input  logic [TICK_W-1:0]     adv_off,
    input  logic [ON_W-1:0]       oe_on,
    input  logic [TICK_W-1:0]     oe_off,
    input  logic [TICK_W-1:0]     acc_time,
    input  logic [TICK_W-1:0]     cyc_time,
    input  logic                  gap_en,
    input  logic [GAP_W-1:0]      gap_len,
    output logic                  done,
    output logic [RES_W-1:0]      rd_data,
    output logic                  cs_n,
    output logic                  adv_n,
    output logic                  oe_n,
    output logic                  dir_in,
    output logic                  ad_oe,
    output logic [MUX_W-1:0]      ad_out,
    input  logic [MUX_W-1:0]      ad_in,
    output logic [HI_W-1:0]       addr_hi
);

    localparam int N_STROBE = 3;

    seq_state_e            state, state_nx;
    rd_timing_t            cfg_in, cfg_q;
    logic [WORD_IDX_W-1:0] word_q;
    logic                  half_q, half_nx;
    logic                  cnt_clr, cnt_inc;
    logic [TICK_W-1:0]     tick;
    logic                  in_acc;
    logic                  tick_last, gap_last, gap_used;
    logic                  cap;
    logic [N_STROBE-1:0]   win_hit;
    logic [N_STROBE-1:0][ON_W-1:0]   win_on;
    logic [N_STROBE-1:0][TICK_W-1:0] win_off;

    assign cfg_in = '{
        cs_on:    cs_on,
        cs_off:   cs_off,
        adv_on:   adv_on,
        adv_off:  adv_off,
        oe_on:    oe_on,
        oe_off:   oe_off,
        acc_time: acc_time,
        cyc_time: cyc_time,
        gap_en:   gap_en,
        gap_len:  gap_len
    };

    // State register with the values sampled at acceptance.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            half_q <= 1'b0;
            cfg_q  <= '0;
            word_q <= '0;
        end else begin
            state  <= state_nx;
            half_q <= half_nx;
            if (state == ST_IDLE && req_valid) begin
                cfg_q  <= cfg_in;
                word_q <= req_word;
            end
        end
    end

    assign tick_last = (tick == cfg_q.cyc_time - TICK_W'(1));
    assign gap_last  = (tick == TICK_W'(cfg_q.gap_len) - TICK_W'(1));
    assign gap_used  = cfg_q.gap_en && (cfg_q.gap_len != '0);

    // Next state and counter control.
    always_comb begin
        state_nx = state;
        half_nx  = half_q;
        cnt_clr  = 1'b0;
        cnt_inc  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                cnt_clr = 1'b1;
                if (req_valid) begin
                    state_nx = ST_ACCESS;
                    half_nx  = 1'b0;
                end
            end
            ST_ACCESS: begin
                if (tick_last) begin
                    cnt_clr = 1'b1;
                    if (half_q) begin
                        state_nx = ST_DONE;
                    end else if (gap_used) begin
                        state_nx = ST_GAP;
                    end else begin
                        half_nx = 1'b1;
                    end
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            ST_GAP: begin
                if (gap_last) begin
                    cnt_clr  = 1'b1;
                    state_nx = ST_ACCESS;
                    half_nx  = 1'b1;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            ST_DONE: begin
                cnt_clr  = 1'b1;
                state_nx = ST_IDLE;
            end
        endcase
    end

    amux_rd_tick_cnt #(.W(TICK_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .tick  (tick)
    );

    assign in_acc = (state == ST_ACCESS);

    assign win_on[0]  = cfg_q.cs_on;
    assign win_off[0] = cfg_q.cs_off;
    assign win_on[1]  = cfg_q.adv_on;
    assign win_off[1] = cfg_q.adv_off;
    assign win_on[2]  = cfg_q.oe_on;
    assign win_off[2] = cfg_q.oe_off;

    for (genvar s = 0; s < N_STROBE; s++) begin : g_strobe
        amux_rd_window #(.ON_W(ON_W), .TICK_W(TICK_W)) u_win (
            .active (in_acc),
            .tick   (tick),
            .t_on   (win_on[s]),
            .t_off  (win_off[s]),
            .hit    (win_hit[s])
        );
    end

    assign cap = in_acc && (tick == cfg_q.acc_time);

    amux_rd_assemble #(.HALF_W(MUX_W), .PARTS(2)) u_asm (
        .clk   (clk),
        .rst_n (rst_n),
        .cap   (cap),
        .sel   (half_q),
        .din   (ad_in),
        .word  (rd_data)
    );

    // Output decode from state, tick and sampled values.
    always_comb begin
        req_ready = (state == ST_IDLE);
        done      = (state == ST_DONE);
        cs_n      = !win_hit[0];
        adv_n     = !win_hit[1];
        oe_n      = !win_hit[2];
        dir_in    = in_acc && (tick >= TICK_W'(cfg_q.oe_on));
        ad_oe     = in_acc && (tick < cfg_q.adv_off);
        ad_out    = ad_oe ? {word_q[MUX_W-2:0], half_q} : '0;
        addr_hi   = word_q[WORD_IDX_W-1:MUX_W-1];
    end

endmodule

// File: rtl/amux_rd_seq_chk.sv
module amux_rd_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic done,
    input logic cs_n,
    input logic adv_n,
    input logic oe_n,
    input logic dir_in,
    input logic ad_oe
);

    // R1
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (cs_n && adv_n && oe_n && !ad_oe && !done));

    // R3
    oe_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> dir_in);

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> req_ready);

    // R6
    done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_ready);

endmodule

bind amux_rd_seq amux_rd_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .done      (done),
    .cs_n      (cs_n),
    .adv_n     (adv_n),
    .oe_n      (oe_n),
    .dir_in    (dir_in),
    .ad_oe     (ad_oe)
);

// File: tb/amux_rd_seq_tb.sv
`timescale 1ns/1ps
module amux_rd_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [25:0] req_word = '0;
    logic [3:0]  b_cs_on = '0, b_adv_on = '0, b_oe_on = '0, b_gap_len = '0;
    logic [4:0]  b_cs_off = '0, b_adv_off = '0, b_oe_off = '0, b_acc = '0, b_cyc = '0;
    logic        b_gap_en = 1'b0;
    logic        done, cs_n, adv_n, oe_n, dir_in, ad_oe;
    logic [31:0] rd_data;
    logic [15:0] ad_out;
    logic [15:0] ad_in = '0;
    logic [10:0] addr_hi;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    amux_rd_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_word(req_word), .cs_on(b_cs_on), .cs_off(b_cs_off),
        .adv_on(b_adv_on), .adv_off(b_adv_off), .oe_on(b_oe_on), .oe_off(b_oe_off),
        .acc_time(b_acc), .cyc_time(b_cyc), .gap_en(b_gap_en), .gap_len(b_gap_len),
        .done(done), .rd_data(rd_data), .cs_n(cs_n), .adv_n(adv_n), .oe_n(oe_n),
        .dir_in(dir_in), .ad_oe(ad_oe), .ad_out(ad_out), .ad_in(ad_in), .addr_hi(addr_hi)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] pat(input int h, input int k);
        return 16'(32'h3C00 + h * 32'h4127 + k * 32'h0119);
    endfunction

    task automatic run_read(input int con, input int coff, input int aon, input int aoff,
                            input int oon, input int ooff, input int acc, input int cyc,
                            input bit gen, input int glen, input logic [25:0] word,
                            input bit hold);
        int gaps;
        logic [31:0] exp_word;
        gaps = (gen && glen > 0) ? glen : 0;
        @(negedge clk);
        b_cs_on = 4'(con);  b_cs_off = 5'(coff);
        b_adv_on = 4'(aon); b_adv_off = 5'(aoff);
        b_oe_on = 4'(oon);  b_oe_off = 5'(ooff);
        b_acc = 5'(acc);    b_cyc = 5'(cyc);
        b_gap_en = gen;     b_gap_len = 4'(glen);
        req_word = word;
        req_valid = 1'b1;
        chk("R1 ready before request", 32'(req_ready), 32'd1);
        for (int h = 0; h < 2; h++) begin
            for (int k = 0; k < cyc; k++) begin
                @(negedge clk);
                if (h == 0 && k == 0) begin
                    // R8: scramble live inputs after acceptance
                    req_valid = hold;
                    b_cs_on = ~b_cs_on;   b_cs_off = ~b_cs_off;
                    b_adv_on = ~b_adv_on; b_adv_off = ~b_adv_off;
                    b_oe_on = ~b_oe_on;   b_oe_off = ~b_oe_off;
                    b_acc = ~b_acc;       b_cyc = ~b_cyc;
                    b_gap_en = ~b_gap_en; b_gap_len = ~b_gap_len;
                    req_word = ~req_word;
                end
                chk("R2 cs_n", 32'(cs_n), 32'(!(k >= con && k < coff)));
                chk("R2 adv_n", 32'(adv_n), 32'(!(k >= aon && k < aoff)));
                chk("R3 oe_n", 32'(oe_n), 32'(!(k >= oon && k < ooff)));
                chk("R3 dir_in", 32'(dir_in), 32'(k >= oon));
                chk("R5 ad_oe", 32'(ad_oe), 32'(k < aoff));
                chk("R5 ad_out", 32'(ad_out), (k < aoff) ? 32'({word[14:0], 1'(h)}) : 32'd0);
                chk("R5 addr_hi", 32'(addr_hi), 32'(word[25:15]));
                chk("R8 ready busy", 32'(req_ready), 32'd0);
                ad_in = pat(h, k);
            end
            if (h == 0) begin
                for (int g = 0; g < gaps; g++) begin
                    @(negedge clk);
                    chk("R7 gap strobes", 32'({cs_n, adv_n, oe_n}), 32'd7);
                    chk("R7 gap bus", 32'({ad_oe, dir_in, req_ready}), 32'd0);
                end
            end
        end
        @(negedge clk);
        exp_word = {pat(1, acc), pat(0, acc)};
        chk("R6 done pulse", 32'(done), 32'd1);
        chk("R4 R6 rd_data", rd_data, exp_word);
        chk("R6 ready at done", 32'(req_ready), 32'd0);
        chk("R7 strobes after access", 32'({cs_n, adv_n, oe_n}), 32'd7);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R6 ready after done", 32'(req_ready), 32'd1);
        chk("R6 done cleared", 32'(done), 32'd0);
    endtask

    initial begin
        int run;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 reset ready", 32'(req_ready), 32'd1);
        chk("R9 reset strobes", 32'({cs_n, adv_n, oe_n}), 32'd7);
        chk("R9 reset flags", 32'({done, ad_oe, dir_in}), 32'd0);
        chk("R9 reset data", rd_data, 32'd0);
        run = 0;
        for (int c = 4; c <= 8; c++) begin
            for (int a = 0; a < c; a++) begin
                for (int gm = 0; gm < 3; gm++) begin
                    int con, aoff, ooff;
                    con  = (a + c) % 2;
                    aoff = con + 1 + (c % 2);
                    ooff = c - ((a / 2) % 2);
                    run_read(con, c - (a % 2), con, aoff, aoff, ooff, a, c,
                             gm != 0, (gm == 0) ? 7 : ((gm == 1) ? 0 : (a % 4) + 1),
                             26'(run * 32'h0054E5F1 + 32'h0155AA3), bit'((a + gm) % 2));
                    run++;
                end
            end
        end
        run_read(15, 31, 0, 15, 15, 31, 30, 31, 1'b1, 15, 26'h3FFFFFF, 1'b1);
        run_read(0, 1, 0, 1, 0, 1, 0, 1, 1'b0, 0, 26'h2AAAAAA, 1'b0);
        run_read(0, 1, 0, 1, 0, 1, 0, 1, 1'b1, 1, 26'h1555555, 1'b1);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL R1 watchdog act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule